// File: doc/BRIEF.md
# Nibble-Bus Memory Dump Master

This block takes temporary control of a 4-bit multiplexed memory bus that is clocked by two quadrature phases. When the user asks for a transfer, it first watches the host's clock lines and the host's chip-enable line. It drives nothing until both host clocks have stopped and the host has released the bus for a programmable number of system clocks. It then produces its own pair of bus clocks and its active-low chip-enable and operation strobes. It sends a four-nibble start address, least-significant nibble first, and moves a fixed burst of sixteen nibbles in one direction.

On a read, the incoming nibbles are packed in pairs into bytes and handed out on a byte-wide port. On a write, bytes are fetched from the user port and split into nibbles in the same order. An optional echo pass after a read drives the sixteen captured nibbles back onto the bus with chip-enable held inactive. The memory therefore ignores them, while a bus observer can compare them against what the memory returned. When the burst ends, the block tristates the data lines, parks both clocks high and pulses done.

Top module: `nbm_dump_master`

## Requirements
- R1: After startReq the block stays parked (clocks high, strobes high, data not driven) until both host clock inputs have shown no edge and hostCeN has been high for idleLimit consecutive system clocks. Any host clock edge or a low hostCeN restarts that count. The first bus clock edge follows within idleLimit to idleLimit+8 cycles of the last disturbance.
- R2: Each bit time is 8 phases of QTR_CYC clocks. busClk1 is low in phases 0-1 and 4-5 and high otherwise. busClk2 is low in phases 1-2 and 5-6, so each busClk2 falling edge comes QTR_CYC cycles after a busClk1 falling edge. Successive busClk1 falling edges are 4*QTR_CYC cycles apart. Both clocks rest high outside a transfer.
- R3: A read nibble is captured in phase 4, the second busClk1 falling edge of its bit time. Data that is valid only from phase 0 through phase 4 is captured correctly.
- R4: busCeN and busOpN fall exactly STROBE_DLY cycles after the most recent busClk2 falling edge. STROBE_DLY must be at least 1 and less than 2*QTR_CYC, so a strobe always falls while busClk2 is low.
- R5: The address phase lasts 4 bit times. Bit k drives startAddr[4k+3:4k] with busDataOe high, and busCeN and busOpN low.
- R6: In a read, the 16 data bit times keep busCeN low and busOpN high, with busDataOe low.
- R7: Read data comes out as 8 bytes, each marked by a one-cycle rdValid. Each byte holds the earlier nibble in bits 3:0 and the later nibble in bits 7:4.
- R8: In a write, wrTake pulses 8 times, and wrByte is taken in the cycle wrTake is high. Each byte is driven as bits 3:0 and then bits 7:4, with busCeN and busOpN low and busDataOe high.
- R9: In a read with echoMode set, 16 further bit times drive the captured nibbles in order, with busCeN high, busOpN low and busDataOe high. echoMode has no effect on a write, which still ends after 20 bit times.
- R10: busy rises the cycle after startReq and falls when the bus is released. done is a single-cycle pulse in the cycle busy falls. After release, the data lines are not driven, both clocks are high and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Pulse requesting one transfer (accepted when not busy) |
| writeMode | input | 1 | 1 selects a write burst, 0 a read burst |
| echoMode | input | 1 | Adds the echo pass after a read |
| startAddr | input | 16 | Start address sent in the address phase |
| idleLimit | input | CNT_W | Quiet cycles required before taking the bus |
| hostClk1 | input | 1 | Observed host clock phase 1 |
| hostClk2 | input | 1 | Observed host clock phase 2 |
| hostCeN | input | 1 | Observed host chip-enable line (high when released) |
| busDataIn | input | 4 | Nibble read from the bus |
| wrByte | input | 8 | Byte to be written, taken when wrTake is high |
| busClk1 | output | 1 | Generated clock phase 1 |
| busClk2 | output | 1 | Generated clock phase 2, a quarter period behind |
| busCeN | output | 1 | Active-low chip-enable strobe |
| busOpN | output | 1 | Active-low operation strobe, low while the master drives data |
| busDataOut | output | 4 | Nibble driven onto the bus |
| busDataOe | output | 1 | Output enable for busDataOut |
| rdByte | output | 8 | Packed read byte |
| rdValid | output | 1 | rdByte is valid this cycle |
| wrTake | output | 1 | wrByte is consumed this cycle |
| busy | output | 1 | Transfer pending or in progress |
| done | output | 1 | One-cycle pulse at bus release |

## Verification
Every bus-level result falls at a fixed offset from the generated clocks rather than from the stimulus. The bench therefore locks onto the busClk1 and busClk2 falling edges it observes: it checks the lines at each second busClk1 fall, which is phase 4, and times strobe falls against the latest busClk2 fall. The read nibbles are presented from phase 0 and corrupted at phase 5, so a capture in any other phase shows up in the packed bytes. rdValid appears one cycle after the capture that completes a byte, done appears in the cycle of release, and all of these are sampled at the falling clock edge. Idle entry is the only result with latency through synchronizers, so it is checked against a window of idleLimit to idleLimit+8 cycles.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
  localparam int ADDR_NIB = 4;
  localparam int BURST_NIB = 16;
  localparam int IDX_W = $clog2(BURST_NIB);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ADDR,
    ST_DATA,
    ST_ECHO
  } busState_t;

  typedef enum logic [1:0] {
    SRC_ADDR,
    SRC_WRITE,
    SRC_ECHO
  } nibSrc_t;

  typedef struct packed {
    logic grab;
    logic sample;
    logic wrLoad;
    nibSrc_t src;
    logic [IDX_W-1:0] nibIdx;
  } dpCtrl_t;
endpackage

// File: rtl/nbm_idle_detect.sv
module nbm_idle_detect #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armed,
  input  logic             hostClk1,
  input  logic             hostClk2,
  input  logic             hostCeN,
  input  logic [CNT_W-1:0] idleLimit,
  output logic             idleOk
);
  localparam int LINES = 3;

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] syncA;
  logic [LINES-1:0] syncB;
  logic [1:0]       clkPrev;
  logic             clkEdge;
  logic             released;
  logic [CNT_W-1:0] quietCnt;

  assign rawIn = {hostCeN, hostClk2, hostClk1};

  for (genvar i = 0; i < LINES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[i] <= 1'b0;
        syncB[i] <= 1'b0;
      end else begin
        syncA[i] <= rawIn[i];
        syncB[i] <= syncA[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= '0;
    else       clkPrev <= syncB[1:0];
  end

  assign clkEdge  = |(clkPrev ^ syncB[1:0]);
  assign released = syncB[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
    end else if (!armed || clkEdge || !released) begin
      quietCnt <= '0;
    end else if (quietCnt != idleLimit) begin
      quietCnt <= quietCnt + 1'b1;
    end
  end

  assign idleOk = armed && released && !clkEdge && (quietCnt == idleLimit);
endmodule

// File: rtl/nbm_clkgen.sv
module nbm_clkgen #(
  parameter int QTR_CYC = 2,
  localparam int BIT_CYC = 8 * QTR_CYC,
  localparam int CYC_W = $clog2(BIT_CYC)
) (
  input  logic             active,
  input  logic [CYC_W-1:0] bitCyc,
  output logic             busClk1,
  output logic             busClk2
);
  logic [2:0] phase;

  if ((QTR_CYC & (QTR_CYC - 1)) == 0) begin : g_shift
    localparam int SH = $clog2(QTR_CYC);
    assign phase = 3'(bitCyc >> SH);
  end else begin : g_div
    assign phase = 3'(bitCyc / CYC_W'(QTR_CYC));
  end

  // phase 1 low in 0,1,4,5 ; phase 2 low in 1,2,5,6 (quarter period behind)
  assign busClk1 = !active || phase[1];
  assign busClk2 = !active || (phase[1] ~^ phase[0]);
endmodule

// File: rtl/nbm_ctrl.sv
module nbm_ctrl
  import nbm_pkg::*;
#(
  parameter int QTR_CYC = 2,
  parameter int STROBE_DLY = 1,
  localparam int BIT_CYC = 8 * QTR_CYC,
  localparam int CYC_W = $clog2(BIT_CYC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             writeMode,
  input  logic             echoMode,
  input  logic             idleOk,
  output logic             armed,
  output logic             active,
  output logic [CYC_W-1:0] bitCyc,
  output logic             busCeN,
  output logic             busOpN,
  output logic             busDataOe,
  output logic             wrTake,
  output logic             busy,
  output logic             done,
  output dpCtrl_t          dpc
);
  busState_t        state;
  logic [IDX_W-1:0] bitIdx;
  logic             modeWr;
  logic             modeEcho;
  logic             doneQ;
  logic             bitEnd;
  logic             lastBit;
  logic             holdOff;

  assign bitEnd  = (bitCyc == CYC_W'(BIT_CYC - 1));
  assign lastBit = (state == ST_ADDR) ? (bitIdx == IDX_W'(ADDR_NIB - 1))
                                      : (bitIdx == IDX_W'(BURST_NIB - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCyc   <= '0;
      bitIdx   <= '0;
      modeWr   <= 1'b0;
      modeEcho <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state    <= ST_WAIT;
            modeWr   <= writeMode;
            modeEcho <= echoMode;
          end
        end
        ST_WAIT: begin
          if (idleOk) begin
            state  <= ST_ADDR;
            bitCyc <= '0;
            bitIdx <= '0;
          end
        end
        default: begin
          if (!bitEnd) begin
            bitCyc <= bitCyc + 1'b1;
          end else begin
            bitCyc <= '0;
            if (!lastBit) begin
              bitIdx <= bitIdx + 1'b1;
            end else begin
              bitIdx <= '0;
              if (state == ST_ADDR) begin
                state <= ST_DATA;
              end else if (state == ST_DATA && !modeWr && modeEcho) begin
                state <= ST_ECHO;
              end else begin
                state <= ST_IDLE;
                doneQ <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  // strobes wait for the delayed point after the first phase-2 fall of a segment
  assign holdOff = (bitIdx == '0) && (bitCyc < CYC_W'(QTR_CYC + STROBE_DLY));

  assign armed  = (state == ST_WAIT);
  assign active = (state == ST_ADDR) || (state == ST_DATA) || (state == ST_ECHO);
  assign busy   = (state != ST_IDLE);
  assign done   = doneQ;

  assign busCeN = !(((state == ST_ADDR) && !holdOff) || (state == ST_DATA));
  assign busOpN = !(((state == ST_ADDR) && !holdOff) ||
                    ((state == ST_DATA) && modeWr) ||
                    ((state == ST_ECHO) && !holdOff));
  assign busDataOe = (state == ST_ADDR) || ((state == ST_DATA) && modeWr) ||
                     (state == ST_ECHO);

  always_comb begin
    dpc.grab   = (state == ST_IDLE) && startReq;
    dpc.sample = (state == ST_DATA) && !modeWr && (bitCyc == CYC_W'(4 * QTR_CYC));
    dpc.wrLoad = bitEnd && modeWr &&
                 (((state == ST_ADDR) && lastBit) ||
                  ((state == ST_DATA) && bitIdx[0] && !lastBit));
    dpc.nibIdx = bitIdx;
    unique case (state)
      ST_DATA: dpc.src = SRC_WRITE;
      ST_ECHO: dpc.src = SRC_ECHO;
      default: dpc.src = SRC_ADDR;
    endcase
  end

  assign wrTake = dpc.wrLoad;
endmodule

// File: rtl/nbm_datapath.sv
module nbm_datapath
  import nbm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpCtrl_t     dpc,
  input  logic [15:0] startAddr,
  input  logic [7:0]  wrByte,
  input  logic [3:0]  busDataIn,
  output logic [3:0]  busDataOut,
  output logic [7:0]  rdByte,
  output logic        rdValid
);
  logic [15:0] addrQ;
  logic [7:0]  wrQ;
  logic [3:0]  lowNib;
  logic [3:0]  capNib [BURST_NIB];
  logic [3:0]  addrNib [ADDR_NIB];

  for (genvar k = 0; k < ADDR_NIB; k++) begin : g_addr
    assign addrNib[k] = addrQ[4*k +: 4];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrQ     <= '0;
      lowNib  <= '0;
      rdByte  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= 1'b0;
      if (dpc.grab)   addrQ <= startAddr;
      if (dpc.wrLoad) wrQ   <= wrByte;
      if (dpc.sample) begin
        if (!dpc.nibIdx[0]) begin
          lowNib <= busDataIn;
        end else begin
          rdByte  <= {busDataIn, lowNib};
          rdValid <= 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < BURST_NIB; k++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         capNib[k] <= '0;
      else if (dpc.sample && dpc.nibIdx == IDX_W'(k))    capNib[k] <= busDataIn;
    end
  end

  always_comb begin
    unique case (dpc.src)
      SRC_WRITE: busDataOut = dpc.nibIdx[0] ? wrQ[7:4] : wrQ[3:0];
      SRC_ECHO:  busDataOut = capNib[dpc.nibIdx];
      default:   busDataOut = addrNib[dpc.nibIdx[1:0]];
    endcase
  end
endmodule

// File: rtl/nbm_dump_master.sv
module nbm_dump_master
  import nbm_pkg::*;
#(
  parameter int QTR_CYC = 2,
  parameter int STROBE_DLY = 1,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             writeMode,
  input  logic             echoMode,
  input  logic [15:0]      startAddr,
  input  logic [CNT_W-1:0] idleLimit,
  input  logic             hostClk1,
  input  logic             hostClk2,
  input  logic             hostCeN,
  input  logic [3:0]       busDataIn,
  input  logic [7:0]       wrByte,
  output logic             busClk1,
  output logic             busClk2,
  output logic             busCeN,
  output logic             busOpN,
  output logic [3:0]       busDataOut,
  output logic             busDataOe,
  output logic [7:0]       rdByte,
  output logic             rdValid,
  output logic             wrTake,
  output logic             busy,
  output logic             done
);
  localparam int CYC_W = $clog2(8 * QTR_CYC);

  dpCtrl_t          dpc;
  logic             armed;
  logic             idleOk;
  logic             active;
  logic [CYC_W-1:0] bitCyc;

  nbm_idle_detect #(.CNT_W(CNT_W)) u_idle (
    .clk(clk), .rstN(rstN), .armed(armed),
    .hostClk1(hostClk1), .hostClk2(hostClk2), .hostCeN(hostCeN),
    .idleLimit(idleLimit), .idleOk(idleOk)
  );

  nbm_ctrl #(.QTR_CYC(QTR_CYC), .STROBE_DLY(STROBE_DLY)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .writeMode(writeMode),
    .echoMode(echoMode), .idleOk(idleOk), .armed(armed), .active(active),
    .bitCyc(bitCyc), .busCeN(busCeN), .busOpN(busOpN), .busDataOe(busDataOe),
    .wrTake(wrTake), .busy(busy), .done(done), .dpc(dpc)
  );

  nbm_clkgen #(.QTR_CYC(QTR_CYC)) u_clk (
    .active(active), .bitCyc(bitCyc), .busClk1(busClk1), .busClk2(busClk2)
  );

  nbm_datapath u_dp (
    .clk(clk), .rstN(rstN), .dpc(dpc), .startAddr(startAddr), .wrByte(wrByte),
    .busDataIn(busDataIn), .busDataOut(busDataOut), .rdByte(rdByte),
    .rdValid(rdValid)
  );
endmodule

// File: rtl/nbm_dump_master_chk.sv
module nbm_dump_master_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic busClk1,
  input logic busClk2,
  input logic busCeN,
  input logic busOpN,
  input logic busDataOe,
  input logic rdValid,
  input logic wrTake
);
  p_parked_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (busClk1 && busClk2 && busCeN && busOpN && !busDataOe));

  p_done_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_clk1_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busClk1) |-> busClk2);

  p_clk2_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busClk2) |-> !busClk1);

  p_ce_in_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busCeN) |-> !busClk2);

  p_op_in_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOpN) |-> !busClk2);

  p_read_float_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busCeN && busOpN) |-> !busDataOe);

  p_echo_drive_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busCeN && !busOpN) |-> busDataOe);

  p_rdvalid_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> busy);

  p_take_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrTake |-> (busy && !busCeN));
endmodule

bind nbm_dump_master nbm_dump_master_chk u_chk (.*);

// File: tb/sim_nbm_dump_master.sv
module sim_nbm_dump_master;
  localparam int Q = 2;
  localparam int DLY = 1;
  localparam int LIMIT = 20;

  typedef struct packed {
    logic        wr;
    logic        echo;
    logic [15:0] addr;
    logic [7:0]  seed;
    logic [5:0]  bits;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h1234, 8'h3C, 6'd20},
    '{1'b0, 1'b1, 16'hA5F0, 8'h91, 6'd36},
    '{1'b1, 1'b0, 16'h0001, 8'h5A, 6'd20},
    '{1'b1, 1'b1, 16'hFFFF, 8'hE7, 6'd20},
    '{1'b0, 1'b1, 16'h0000, 8'h0F, 6'd36}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, writeMode = 1'b0, echoMode = 1'b0;
  logic [15:0] startAddr = '0;
  logic [15:0] idleLimit = 16'(LIMIT);
  logic hostClk1 = 1'b0, hostClk2 = 1'b0, hostCeN = 1'b1;
  logic [3:0] busDataIn = '0;
  logic [7:0] wrByte = '0;
  logic busClk1, busClk2, busCeN, busOpN, busDataOe, rdValid, wrTake, busy, done;
  logic [3:0] busDataOut;
  logic [7:0] rdByte;

  always #2 clk = ~clk;

  nbm_dump_master #(.QTR_CYC(Q), .STROBE_DLY(DLY), .CNT_W(16)) u0 (.*);

  int nChk = 0, nFail = 0, cyc = 0;
  int fallCnt, firstFall, lastC1, lastC2, rdCnt, takeCnt, doneCnt;
  logic pendTake;
  logic curWr, curEcho;
  logic [15:0] curAddr;
  logic [7:0] curSeed;
  logic prevC1 = 1'b1, prevC2 = 1'b1, prevCe = 1'b1, prevOp = 1'b1;
  bit finished = 0;

  function automatic logic [3:0] rdNib(input logic [7:0] s, input int k);
    return 4'(s[3:0] + 4'(k * 5)) ^ s[7:4];
  endfunction

  function automatic logic [7:0] wrB(input logic [7:0] s, input int k);
    return 8'(s * 3 + k * 75);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic samplePoint(input int b);
    if (b < 4) begin
      chk(busDataOe && busDataOut == curAddr[4*b +: 4], "R5 address nibble",
          {27'(busDataOe), busDataOut}, {27'(1), curAddr[4*b +: 4]});
      chk(!busCeN && !busOpN, "R5 strobes low", {busCeN, busOpN}, 0);
    end else if (b < 20) begin
      if (curWr) begin
        logic [7:0] by;
        by = wrB(curSeed, (b - 4) / 2);
        chk(busDataOe && busDataOut == (((b - 4) % 2 == 1) ? by[7:4] : by[3:0]),
            "R8 write nibble", busDataOut, ((b - 4) % 2 == 1) ? by[7:4] : by[3:0]);
        chk(!busCeN && !busOpN, "R8 strobes low", {busCeN, busOpN}, 0);
      end else begin
        chk(!busDataOe, "R6 read tristate", busDataOe, 0);
        chk(!busCeN && busOpN, "R6 strobes", {busCeN, busOpN}, 2'b01);
      end
    end else begin
      chk(curEcho && !curWr, "R9 echo only after read with echoMode", b, 20);
      chk(busDataOe && busCeN && !busOpN && busDataOut == rdNib(curSeed, b - 20),
          "R9 echo nibble", {busCeN, busOpN, busDataOut}, {2'b10, rdNib(curSeed, b - 20)});
    end
  endtask

  // bus observer and memory model
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN) begin
        if (pendTake) wrByte = wrB(curSeed, takeCnt);
        pendTake = wrTake;
        if (wrTake) takeCnt++;
        if (prevC1 && !busClk1) begin
          if (fallCnt > 0) chk(cyc - lastC1 == 4 * Q, "R2 clk1 spacing", cyc - lastC1, 4 * Q);
          else firstFall = cyc;
          lastC1 = cyc;
          if (fallCnt % 2 == 0) begin
            if (!curWr && fallCnt / 2 >= 4 && fallCnt / 2 < 20)
              busDataIn = rdNib(curSeed, fallCnt / 2 - 4);
          end else begin
            samplePoint(fallCnt / 2);
          end
          fallCnt++;
        end
        if (prevC2 && !busClk2) begin
          chk(cyc - lastC1 == Q, "R2 clk2 lag", cyc - lastC1, Q);
          lastC2 = cyc;
          if (fallCnt % 2 == 0) busDataIn = ~busDataIn;  // valid window closes after phase 4
        end
        if (prevCe && !busCeN) chk(cyc - lastC2 == DLY, "R4 ce delay", cyc - lastC2, DLY);
        if (prevOp && !busOpN) chk(cyc - lastC2 == DLY, "R4 op delay", cyc - lastC2, DLY);
        if (rdValid) begin
          chk(rdByte == {rdNib(curSeed, 2 * rdCnt + 1), rdNib(curSeed, 2 * rdCnt)},
              "R7 R3 packed byte", rdByte,
              {rdNib(curSeed, 2 * rdCnt + 1), rdNib(curSeed, 2 * rdCnt)});
          rdCnt++;
        end
        if (done) begin
          doneCnt++;
          chk(!busy, "R10 busy low with done", busy, 0);
        end
      end
      prevC1 = busClk1; prevC2 = busClk2; prevCe = busCeN; prevOp = busOpN;
    end
  end

  task automatic startTxn(input vec_t v);
    @(negedge clk);
    curWr = v.wr; curEcho = v.echo; curAddr = v.addr; curSeed = v.seed;
    fallCnt = 0; rdCnt = 0; takeCnt = 0; doneCnt = 0; pendTake = 1'b0;
    wrByte = wrB(v.seed, 0);
    writeMode = v.wr; echoMode = v.echo; startAddr = v.addr;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy, "R10 busy after start", busy, 1);
  endtask

  task automatic finishTxn(input vec_t v);
    int lastFalls;
    for (int t = 0; t < 3000 && doneCnt == 0; t++) @(negedge clk);
    chk(doneCnt == 1, "R10 done pulse", doneCnt, 1);
    chk(fallCnt == 2 * int'(v.bits), "R9 R10 bit count", fallCnt, 2 * v.bits);
    chk(rdCnt == (v.wr ? 0 : 8), "R7 byte count", rdCnt, v.wr ? 0 : 8);
    chk(takeCnt == (v.wr ? 8 : 0), "R8 take count", takeCnt, v.wr ? 8 : 0);
    lastFalls = fallCnt;
    repeat (30) @(negedge clk);
    chk(fallCnt == lastFalls && doneCnt == 1, "R10 quiet after release", fallCnt, lastFalls);
    chk(busClk1 && busClk2 && busCeN && busOpN && !busDataOe && !busy,
        "R10 parked", {busClk1, busClk2, busCeN, busOpN, busDataOe, busy}, 6'b111100);
  endtask

  initial begin
    int m;
    curWr = 0; curEcho = 0; curAddr = 0; curSeed = 0; pendTake = 0;
    fallCnt = 0; rdCnt = 0; takeCnt = 0; doneCnt = 0; lastC1 = 0; lastC2 = 0; firstFall = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !busDataOe && !rdValid && !wrTake, "R10 reset state",
        {busy, done, busDataOe, rdValid, wrTake}, 0);
    chk(busClk1 && busClk2 && busCeN && busOpN, "R2 reset clocks parked",
        {busClk1, busClk2, busCeN, busOpN}, 4'hF);

    // R1: host activity holds the master off
    hostCeN = 1'b1;
    startTxn(VECS[0]);
    for (int t = 0; t < 80; t++) begin
      @(negedge clk);
      if (t % 5 == 0) hostClk1 = ~hostClk1;
      if (t % 5 == 2) hostClk2 = ~hostClk2;
    end
    chk(fallCnt == 0 && busCeN, "R1 no start while host clocks run", fallCnt, 0);
    hostCeN = 1'b0;
    repeat (60) @(negedge clk);
    chk(fallCnt == 0 && busy, "R1 no start while host holds ce", fallCnt, 0);
    hostCeN = 1'b1;
    m = cyc;
    for (int t = 0; t < 200 && fallCnt == 0; t++) @(negedge clk);
    chk(firstFall - m >= LIMIT && firstFall - m <= LIMIT + 8, "R1 idle entry window",
        firstFall - m, LIMIT);
    finishTxn(VECS[0]);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      startTxn(VECS[i]);
      finishTxn(VECS[i]);
    end

    // R1: zero limit still waits for a released bus
    idleLimit = '0;
    hostCeN = 1'b0;
    startTxn(VECS[1]);
    repeat (40) @(negedge clk);
    chk(fallCnt == 0, "R1 zero limit held by ce", fallCnt, 0);
    hostCeN = 1'b1;
    finishTxn(VECS[1]);

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule